// File: doc/BRIEF.md
# Two-Wire Debug Register Slave

This block is the target end of a two-wire synchronous debug link: one serial clock line driven by the master and one data line shared by both sides. Both lines are brought into the system clock domain through a two-flop synchronizer. All framing and bit handling runs on the synchronized copies, so the serial clock must be several system clocks per half period.

A frame opens with a start condition, which is the data line falling while the serial clock is high. It closes with a stop condition, which is the data line rising while the serial clock is high. The first byte of a frame names a register and a direction. In a write frame, every data byte produces a one-cycle write strobe, and the register index then advances, saturating at the top of the write-only range. In a read frame, the block requests register contents through a request port and shifts the value back to the master. A single separator bit follows every byte.

Top module: `dbg_link_slave`

## Requirements
- R1: A start condition, including one issued in the middle of a frame, makes the next eight rising serial clock edges the address byte. After a stop condition, serial clock edges produce no write strobe and no read request.
- R2: The address byte carries a 7-bit register index, most significant bit first. Its eighth bit is the direction flag: 0 selects a write and 1 selects a read.
- R3: A separator bit follows every byte, and its sampled value, 0 or 1, has no effect on the transfer.
- R4: In a write frame, `wr_en_o` is high for exactly one system clock after the eighth data bit of each byte. The received byte (first bit = bit 7) appears on `wr_data_o`, and the current index appears on `wr_addr_o`.
- R5: After each written byte, the index becomes index+1 if it was below 0x30. Otherwise it keeps its value, so every later byte in the frame writes to that same index.
- R6: In a read frame, `rd_req_o` pulses for one system clock after each separator bit, with the index on `rd_addr_o`. The value on `rd_data_i` during that pulse is the byte returned next.
- R7: Read data leaves most significant bit first. `ser_dat_o` changes only after a falling serial clock edge, and `ser_dat_oe` is high only during the eight data bit slots of a read byte.
- R8: In a read frame, the index advances by one modulo 128 after each byte, and a request is also issued at the separator that follows the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock line from the master |
| ser_dat_i | input | 1 | Data line as seen at the pin |
| ser_dat_o | output | 1 | Data value driven by the slave |
| ser_dat_oe | output | 1 | Output enable for the data line |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register index for the write |
| wr_data_o | output | 8 | Byte to write |
| rd_req_o | output | 1 | One-cycle register read request |
| rd_addr_o | output | 7 | Register index to read |
| rd_data_i | input | 8 | Register value, valid while `rd_req_o` is high |

## Verification
Write frames start below, at, just below and above the 0x30 limit. This separates plain increment from saturation and from a start index that is already past the limit, and the data and separator values vary from byte to byte. Read frames start at an ordinary index, just below the limit and near 127. This shows that reads do not saturate, that they wrap, and that each returned byte matches the request that preceded it. A restart cut into an address byte, and serial clocks sent after a stop, show that framing resets the bit position and that idle traffic has no effect.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_t;

  function automatic logic [6:0] wr_next(input logic [6:0] a, input logic [6:0] top);
    return (a >= top) ? a : a + 7'd1;
  endfunction

  function automatic logic [6:0] rd_next(input logic [6:0] a);
    return a + 7'd1;
  endfunction
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dbg_cond_detect.sv
module dbg_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
  assign start_o = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dbg_frame_engine.sv
module dbg_frame_engine
  import dbg_link_pkg::*;
#(
  parameter int          AW     = 7,
  parameter int          DW     = 8,
  parameter logic [6:0]  WR_TOP = 7'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  output logic          dat_o,
  output logic          oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
  localparam logic [BCW-1:0] SEP_BIT  = BCW'(DW);

  phase_t        phase_q;
  logic          in_frame_q, rw_q;
  logic [BCW-1:0] bcnt_q;
  logic [DW-1:0] rxsh_q, txsh_q;
  logic [AW-1:0] addr_q;
  logic          dout_q, oe_q;

  wire bit_edge  = in_frame_q & rise_i & ~start_i & ~stop_i;
  wire at_sep    = (bcnt_q == SEP_BIT);
  wire at_last   = (bcnt_q == LAST_BIT);
  wire tx_fall   = in_frame_q & fall_i & (phase_q == PH_DATA) & rw_q;
  wire [DW-1:0] rx_byte = {rxsh_q[DW-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_ADDR;
      in_frame_q <= 1'b0;
      rw_q       <= 1'b0;
      bcnt_q     <= '0;
      rxsh_q     <= '0;
      txsh_q     <= '0;
      addr_q     <= '0;
      dout_q     <= 1'b0;
      oe_q       <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      wr_en_o  <= 1'b0;
      rd_req_o <= 1'b0;
      if (start_i) begin
        in_frame_q <= 1'b1;
        phase_q    <= PH_ADDR;
        bcnt_q     <= '0;
        oe_q       <= 1'b0;
      end else if (stop_i) begin
        in_frame_q <= 1'b0;
        bcnt_q     <= '0;
        oe_q       <= 1'b0;
      end else if (bit_edge) begin
        if (at_sep) begin
          bcnt_q  <= '0;
          phase_q <= PH_DATA;
          if (rw_q) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= addr_q;
          end
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
          rxsh_q <= rx_byte;
          if (at_last) begin
            if (phase_q == PH_ADDR) begin
              addr_q <= rxsh_q[AW-1:0];
              rw_q   <= sda_i;
            end else if (!rw_q) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= rx_byte;
              addr_q    <= wr_next(addr_q, WR_TOP);
            end else begin
              addr_q <= rd_next(addr_q);
            end
          end
        end
      end else if (tx_fall) begin
        if (!at_sep) begin
          dout_q <= txsh_q[DW-1];
          txsh_q <= {txsh_q[DW-2:0], 1'b0};
          oe_q   <= 1'b1;
        end else begin
          oe_q <= 1'b0;
        end
      end
      if (rd_req_o) txsh_q <= rd_data_i;
    end
  end

  assign dat_o = dout_q;
  assign oe_o  = oe_q;

  p_start_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (bcnt_q == '0 && phase_q == PH_ADDR && in_frame_q));
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  p_addr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o < WR_TOP) |=> (addr_q == $past(wr_addr_o) + 7'd1));
  p_addr_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o >= WR_TOP) |=> (addr_q == $past(wr_addr_o)));
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (rw_q && phase_q == PH_DATA));
  p_dout_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(dout_q));
endmodule

// File: rtl/dbg_link_slave.sv
module dbg_link_slave #(
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter logic [6:0] WR_TOP      = 7'h30,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk_i,
  input  logic          ser_dat_i,
  output logic          ser_dat_o,
  output logic          ser_dat_oe,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  logic [1:0] lines_s;
  logic       ev_rise, ev_fall, ev_start, ev_stop;

  dbg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_clk_i, ser_dat_i}), .sync_o(lines_s)
  );

  dbg_cond_detect i_cond (
    .clk(clk), .rst_n(rst_n),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .rise_o(ev_rise), .fall_o(ev_fall), .start_o(ev_start), .stop_o(ev_stop)
  );

  dbg_frame_engine #(.AW(AW), .DW(DW), .WR_TOP(WR_TOP)) i_engine (
    .clk(clk), .rst_n(rst_n),
    .rise_i(ev_rise), .fall_i(ev_fall), .start_i(ev_start), .stop_i(ev_stop),
    .sda_i(lines_s[0]),
    .dat_o(ser_dat_o), .oe_o(ser_dat_oe),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );
endmodule

// File: tb/test_dbg_link_slave.sv
module test_dbg_link_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic dat_o, dat_oe, wr_en, rd_req;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  int wa [64]; int wd [64]; int wn = 0;
  int ra [64]; int rn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] reg_val(input logic [6:0] a);
    return ({1'b0, a} * 8'd3) ^ 8'h5C;
  endfunction
  assign rd_data = reg_val(rd_addr);

  dbg_link_slave i_dbg_link_slave (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(scl), .ser_dat_i(sda),
    .ser_dat_o(dat_o), .ser_dat_oe(dat_oe),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(negedge clk) begin
    if (wr_en && wn < 64) begin wa[wn] = wr_addr; wd[wn] = wr_data; wn++; end
    if (rd_req && rn < 64) begin ra[rn] = rd_addr; rn++; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda = 1'b1; cyc(HALF); scl = 1'b1; cyc(HALF);
    sda = 1'b0; cyc(HALF); scl = 1'b0; cyc(HALF);
  endtask

  task automatic do_stop();
    sda = 1'b0; cyc(HALF); scl = 1'b1; cyc(HALF); sda = 1'b1; cyc(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda = b; cyc(HALF); scl = 1'b1; cyc(HALF/2);
    chk(dat_oe == 1'b0, "R7", "oe while master drives", dat_oe, 0);
    cyc(HALF/2); scl = 1'b0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(rw);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(HALF); scl = 1'b1; cyc(HALF/2);
      chk(dat_oe == 1'b1, "R7", "oe during read bit", dat_oe, 1);
      v[i] = dat_o;
      cyc(HALF/2); scl = 1'b0;
    end
  endtask

  task automatic write_frame(input logic [6:0] a0, input int n);
    logic [6:0] ea;
    int base;
    base = wn; ea = a0;
    do_start(); send_addr(a0, 1'b0); send_bit(a0[0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(a0 * 7 + k * 29 + 3);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      send_bit(1'(k));
      chk(wn == base + k + 1, "R4", "strobe count", wn, base + k + 1);
      chk(wa[base+k] == int'(ea), "R5", "write index", wa[base+k], ea);
      chk(wd[base+k] == int'(d), "R4", "write byte", wd[base+k], d);
      if (ea < 7'd48) ea = ea + 7'd1;
    end
    do_stop();
  endtask

  task automatic read_frame(input logic [6:0] a0, input int n);
    int base;
    logic [6:0] ea;
    logic [7:0] v;
    base = rn; ea = a0;
    do_start(); send_addr(a0, 1'b1); send_bit(1'b1);
    for (int k = 0; k < n; k++) begin
      recv_byte(v);
      chk(v == reg_val(ea), "R6", "read byte", v, reg_val(ea));
      chk(ra[base+k] == int'(ea), "R8", "read index", ra[base+k], ea);
      send_bit(~1'(k));
      ea = 7'((int'(ea) + 1) % 128);
    end
    chk(rn == base + n + 1, "R8", "request count", rn, base + n + 1);
    chk(ra[base+n] == int'(ea), "R8", "prefetch index", ra[base+n], ea);
    do_stop();
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int snap;
    cyc(5); rst_n = 1'b1; cyc(3);
    chk(dat_oe == 0 && wr_en == 0 && rd_req == 0, "R1", "reset outputs", {dat_oe, wr_en, rd_req}, 0);

    // R2 R4 R5 R3: write sweep across the saturation limit
    write_frame(7'h00, 3);
    write_frame(7'h15, 2);
    write_frame(7'h2D, 6);
    write_frame(7'h30, 3);
    write_frame(7'h55, 3);
    write_frame(7'h2F, 1);

    // R1: restart mid-address, then a clean write
    do_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    snap = wn;
    sda = 1'b1; cyc(HALF); scl = 1'b1; cyc(HALF); sda = 1'b0; cyc(HALF); scl = 1'b0; cyc(HALF);
    send_addr(7'h0A, 1'b0); send_bit(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(1'(8'hC3 >> i));
    send_bit(1'b1);
    chk(wn == snap + 1 && wa[snap] == 'h0A && wd[snap] == 'hC3, "R1", "restart write", wa[snap], 'h0A);
    do_stop();

    // R1: clocks after a stop are ignored
    snap = wn;
    scl = 1'b0; cyc(HALF);
    for (int i = 0; i < 27; i++) send_bit(1'(i % 3));
    chk(wn == snap && rn == 0, "R1", "idle strobes", wn - snap + rn, 0);

    // R6 R7 R8: reads without saturation, with wrap
    read_frame(7'h10, 3);
    read_frame(7'h2F, 3);
    read_frame(7'h7E, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule